// File: doc/BRIEF.md
# Write Completion Status Poller

This host-side controller finds out when a byte-alterable nonvolatile memory has finished its internal programming cycle after a byte or page write. After a write, the host pulses a start input. With that pulse it supplies the address and data it wrote last and picks one of two detection methods. The controller then issues ordinary read cycles through a request/acknowledge handshake and examines each returned byte. It stops reading as soon as the memory shows that programming has ended.

In the inversion method, the controller reads the saved address over and over. While programming is in progress, bit 7 of the returned byte is the complement of bit 7 of the written data. Programming has ended when that bit matches the written value. In the toggle method, the controller ignores the written data and watches bit 6. That bit flips on every read while the memory is busy. Programming has ended when two consecutive reads return the same value. The memory needs a short recovery gap after completion before it accepts another write, so the controller waits out that gap before it raises its done flag. If no completion is seen within a long, parameterised limit, the controller stops polling and raises a timeout flag. Both flags stay up until the next accepted start.

Top module: `wrpoll_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `done_o`, `timeout_o` and `busy_o` are all low.
- R2: A start pulse accepted while the block is not busy captures the address, the data and the method, and clears both flags. From the next cycle on, `busy_o` is high. Every read issued in that run presents the captured address on `rd_addr_o`.
- R3: With `method_i` = 0 (inversion method), a read whose bit 7 is the complement of bit 7 of the captured data keeps polling going. The first read whose bit 7 equals the captured bit 7 ends polling.
- R4: With `method_i` = 1 (toggle method), the first read of a run never ends polling. Any later read whose bit 6 equals bit 6 of the read just before it ends polling.
- R5: `rd_req_o` stays high until a cycle in which `rd_ack_i` is high. Each such cycle consumes exactly one read. The `rd_data_i` byte is sampled in that same cycle.
- R6: `done_o` rises exactly GAP_US*CLK_MHZ clock cycles after the clock edge that samples the completing acknowledge. `busy_o` stays high and `rd_req_o` stays low during that gap.
- R7: If polling has not ended, `timeout_o` rises exactly TIMEOUT_US*CLK_MHZ cycles after the clock edge that accepted the start pulse. `rd_req_o` then falls and no further reads are issued.
- R8: `done_o` and `timeout_o` hold their value until the next accepted start pulse. That start pulse clears both flags on the same edge.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running poll keeps its address, data and method.
- R10: `done_o` and `timeout_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request to begin polling |
| method_i | input | 1 | 0: bit-7 inversion method, 1: bit-6 toggle method |
| last_addr_i | input | AW | Address of the last byte written |
| last_data_i | input | 8 | Last byte written |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read response valid, one cycle per read |
| rd_data_i | input | 8 | Read data, valid with `rd_ack_i` |
| busy_o | output | 1 | Polling or recovery gap in progress |
| done_o | output | 1 | Programming finished and recovery gap elapsed |
| timeout_o | output | 1 | Polling abandoned after the time limit |

## Verification
The assertions assume a well-behaved read port: `rd_ack_i` is raised only while `rd_req_o` is high, for one cycle per read, with `rd_data_i` valid in that cycle. They also assume `start_i` is a pulse that lasts one cycle. The bench's memory model drives the acknowledge only at a falling edge, only after it has seen the request high for a fixed latency, and drops it one cycle later. It produces the inverted bit 7 and the flipping bit 6 for a chosen number of busy reads, so that each run's read count and completion edge can be predicted exactly. Every start pulse is a single cycle long and is driven away from the active edge.

// File: rtl/wrpoll_pkg.sv
package wrpoll_pkg;
  localparam int BYTE_W  = 8;
  localparam int INV_BIT = 7;
  localparam int TOG_BIT = 6;

  typedef enum logic {
    MODE_INV7 = 1'b0,
    MODE_TOG6 = 1'b1
  } poll_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_POLL   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_DONE   = 3'd3,
    ST_TOUT   = 3'd4
  } poll_st_t;
endpackage

// File: rtl/wrpoll_window.sv
module wrpoll_window #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = val_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !en_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/wrpoll_ctx.sv
module wrpoll_ctx
  import wrpoll_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ref_i,
  input  poll_mode_t    mode_i,
  output logic [AW-1:0] addr_o,
  output logic          ref_o,
  output poll_mode_t    mode_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          ref_q, ref_d;
  poll_mode_t    mode_q, mode_d;

  always_comb begin
    addr_d = addr_q;
    ref_d  = ref_q;
    mode_d = mode_q;
    if (load_i) begin
      addr_d = addr_i;
      ref_d  = ref_i;
      mode_d = mode_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ref_q  <= 1'b0;
      mode_q <= MODE_INV7;
    end else begin
      addr_q <= addr_d;
      ref_q  <= ref_d;
      mode_q <= mode_d;
    end
  end

  assign addr_o = addr_q;
  assign ref_o  = ref_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/wrpoll_judge.sv
module wrpoll_judge
  import wrpoll_pkg::*;
(
  input  poll_mode_t mode_i,
  input  logic       inv_bit_i,
  input  logic       tog_bit_i,
  input  logic       ref_i,
  input  logic       prev_i,
  input  logic       have_prev_i,
  output logic       finished_o
);
  always_comb begin
    if (mode_i == MODE_INV7) begin
      finished_o = (inv_bit_i == ref_i);
    end else begin
      finished_o = have_prev_i && (tog_bit_i == prev_i);
    end
  end
endmodule

// File: rtl/wrpoll_ctrl.sv
module wrpoll_ctrl
  import wrpoll_pkg::*;
#(
  parameter int AW         = 15,
  parameter int CLK_MHZ    = 200,
  parameter int TIMEOUT_US = 5000,
  parameter int GAP_US     = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              method_i,
  input  logic [AW-1:0]     last_addr_i,
  input  logic [BYTE_W-1:0] last_data_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int TO_CYC  = TIMEOUT_US * CLK_MHZ;
  localparam int GAP_CYC = GAP_US * CLK_MHZ;
  localparam int TO_W    = $clog2(TO_CYC + 1);
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_sync_q;

  poll_st_t st_q, st_d;
  logic accept, ack_fire, finished, to_zero, gap_zero;
  logic prev_q, prev_d, have_prev_q, have_prev_d;
  logic ref_bit;
  poll_mode_t mode_q;

  logic unused_bits;
  assign unused_bits = ^{rd_data_i[TOG_BIT-1:0], last_data_i[INV_BIT-1:0]};

  assign accept   = start_i && (st_q != ST_POLL) && (st_q != ST_SETTLE);
  assign ack_fire = (st_q == ST_POLL) && rd_ack_i;

  wrpoll_ctx #(.AW(AW)) u_ctx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (accept),
    .addr_i (last_addr_i),
    .ref_i  (last_data_i[INV_BIT]),
    .mode_i (poll_mode_t'(method_i)),
    .addr_o (rd_addr_o),
    .ref_o  (ref_bit),
    .mode_o (mode_q)
  );

  wrpoll_judge u_judge (
    .mode_i      (mode_q),
    .inv_bit_i   (rd_data_i[INV_BIT]),
    .tog_bit_i   (rd_data_i[TOG_BIT]),
    .ref_i       (ref_bit),
    .prev_i      (prev_q),
    .have_prev_i (have_prev_q),
    .finished_o  (finished)
  );

  wrpoll_window #(.W(TO_W)) u_limit (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (accept),
    .val_i  (TO_W'(TO_CYC - 1)),
    .en_i   (st_q == ST_POLL),
    .zero_o (to_zero)
  );

  wrpoll_window #(.W(GAP_W)) u_gap (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (ack_fire && finished),
    .val_i  (GAP_W'(GAP_CYC - 1)),
    .en_i   (st_q == ST_SETTLE),
    .zero_o (gap_zero)
  );

  // previous bit-6 sample for the toggle method
  always_comb begin
    prev_d      = prev_q;
    have_prev_d = have_prev_q;
    if (accept) begin
      have_prev_d = 1'b0;
    end else if (ack_fire) begin
      prev_d      = rd_data_i[TOG_BIT];
      have_prev_d = 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_DONE, ST_TOUT: begin
        if (accept) st_d = ST_POLL;
      end
      ST_POLL: begin
        if (ack_fire && finished) st_d = ST_SETTLE;
        else if (to_zero)         st_d = ST_TOUT;
      end
      ST_SETTLE: begin
        if (gap_zero) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q        <= ST_IDLE;
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      prev_q      <= prev_d;
      have_prev_q <= have_prev_d;
    end
  end

  assign rd_req_o  = (st_q == ST_POLL);
  assign busy_o    = (st_q == ST_POLL) || (st_q == ST_SETTLE);
  assign done_o    = (st_q == ST_DONE);
  assign timeout_o = (st_q == ST_TOUT);

  AST_REQ_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_req_o && !rd_ack_i && !to_zero) |=> rd_req_o); // R5
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_req_o |=> (!rd_req_o || $stable(rd_addr_o))); // R2
  AST_FIRST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack_fire && (mode_q == MODE_TOG6) && !have_prev_q) |=> (rd_req_o || timeout_o)); // R4
  AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(done_o) |-> ($past(busy_o) && !$past(rd_req_o))); // R6
  AST_TOUT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    timeout_o |-> !rd_req_o); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !start_i) |=> done_o); // R8
  AST_TOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (timeout_o && !start_i) |=> timeout_o); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i) |=> busy_o || done_o || timeout_o); // R9
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(done_o && timeout_o)); // R10
endmodule

// File: tb/test_wrpoll_ctrl.sv
`timescale 1ns/1ps
module test_wrpoll_ctrl;
  localparam int AW   = 15;
  localparam int MHZ  = 200;
  localparam int TOUS = 2;
  localparam int GPUS = 10;
  localparam int TO   = TOUS * MHZ;
  localparam int GAP  = GPUS * MHZ;
  localparam int LAT  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic method_i = 1'b0;
  logic [AW-1:0] last_addr_i = '0;
  logic [7:0] last_data_i = '0;
  logic rd_ack_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic rd_req_o, busy_o, done_o, timeout_o;
  logic [AW-1:0] rd_addr_o;

  always #2.5 clk = ~clk;

  wrpoll_ctrl #(.AW(AW), .CLK_MHZ(MHZ), .TIMEOUT_US(TOUS), .GAP_US(GPUS)) i_wrpoll_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .method_i(method_i),
    .last_addr_i(last_addr_i), .last_data_i(last_data_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // memory model state
  int busy_left = 0;
  logic [7:0] stored = '0;
  logic tog = 1'b0;
  int reads = 0;
  int last_ack_edge = 0;
  logic [AW-1:0] exp_addr = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : responder
    int wait_n;
    wait_n = 0;
    forever begin
      @(negedge clk);
      rd_ack_i = 1'b0;
      if (rd_req_o) begin
        wait_n++;
        if (wait_n == LAT) begin
          wait_n = 0;
          chk(rd_addr_o == exp_addr, "R2 read address", rd_addr_o, exp_addr);
          if (busy_left > 0) begin
            rd_data_i = {~stored[7], tog, stored[5:0]};
            tog = ~tog;
            busy_left--;
          end else begin
            rd_data_i = {stored[7], tog, stored[5:0]};
          end
          rd_ack_i = 1'b1;
          reads++;
          last_ack_edge = cyc + 1;
        end
      end else begin
        wait_n = 0;
      end
    end
  end

  int start_edge = 0;

  task automatic pulse_start(input logic m, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    method_i = m; last_addr_i = a; last_data_i = d; start_i = 1'b1;
    start_edge = cyc + 1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic setup_model(input logic [AW-1:0] a, input logic [7:0] d, input int k);
    exp_addr = a; stored = d; tog = d[6]; busy_left = k; reads = 0;
  endtask

  task automatic wait_end(output int edge_at);
    edge_at = -1;
    for (int i = 0; i < 4 * GAP; i++) begin
      @(negedge clk);
      if (done_o || timeout_o) begin
        edge_at = cyc;
        break;
      end
    end
  endtask

  task automatic run_poll(input logic m, input logic [AW-1:0] a, input logic [7:0] d,
                          input int k, input int exp_reads, input string req);
    int e;
    setup_model(a, d, k);
    pulse_start(m, a, d);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    wait_end(e);
    chk(done_o == 1'b1, req, done_o, 1);
    chk(timeout_o == 1'b0, "R10 no timeout with done", timeout_o, 0);
    chk(reads == exp_reads, req, reads, exp_reads);
    chk(e - last_ack_edge == GAP, "R6 recovery gap", e - last_ack_edge, GAP);
    chk(rd_req_o == 1'b0, "R6 no request after done", rd_req_o, 0);
  endtask

  task automatic t_reset();
    chk(rd_req_o == 1'b0, "R1 req after reset", rd_req_o, 0);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    chk(timeout_o == 1'b0, "R1 timeout after reset", timeout_o, 0);
  endtask

  task automatic t_inv7();
    run_poll(1'b0, 15'h1234, 8'h3C, 3, 4, "R3 inversion, bit7 ref 0");
    run_poll(1'b0, 15'h7F80, 8'hA5, 5, 6, "R3 inversion, bit7 ref 1");
    run_poll(1'b0, 15'h0001, 8'h80, 0, 1, "R3 inversion, already finished");
  endtask

  task automatic t_tog6();
    run_poll(1'b1, 15'h0456, 8'h40, 3, 5, "R4 toggle, 3 busy reads");
    run_poll(1'b1, 15'h2AAA, 8'h00, 0, 2, "R4 toggle, first read never finishes");
  endtask

  task automatic t_sticky_done();
    int e;
    repeat (100) @(negedge clk);
    chk(done_o == 1'b1, "R8 done held", done_o, 1);
    setup_model(15'h0777, 8'h11, 2);
    pulse_start(1'b0, 15'h0777, 8'h11);
    chk(done_o == 1'b0, "R8 start clears done", done_o, 1'b0);
    wait_end(e);
    chk(done_o == 1'b1, "R3 after restart", done_o, 1);
  endtask

  task automatic t_busy_start();
    int e;
    setup_model(15'h0100, 8'h80, 3);
    pulse_start(1'b0, 15'h0100, 8'h80);
    repeat (2) @(negedge clk);
    method_i = 1'b1; last_addr_i = 15'h5555; last_data_i = 8'h00; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_end(e);
    chk(done_o == 1'b1, "R9 done with original context", done_o, 1);
    chk(reads == 4, "R9 reads with original data", reads, 4);
  endtask

  task automatic t_timeout();
    int e, r;
    setup_model(15'h3210, 8'h7E, 1000000);
    pulse_start(1'b0, 15'h3210, 8'h7E);
    wait_end(e);
    chk(timeout_o == 1'b1, "R7 timeout raised", timeout_o, 1);
    chk(done_o == 1'b0, "R10 no done with timeout", done_o, 0);
    chk(e - start_edge == TO, "R7 timeout edge", e - start_edge, TO);
    r = reads;
    repeat (40) @(negedge clk);
    chk(rd_req_o == 1'b0, "R7 request dropped", rd_req_o, 0);
    chk(reads == r, "R7 no reads after timeout", reads, r);
    chk(timeout_o == 1'b1, "R8 timeout held", timeout_o, 1);
    setup_model(15'h3210, 8'h7E, 1);
    pulse_start(1'b0, 15'h3210, 8'h7E);
    chk(timeout_o == 1'b0, "R8 start clears timeout", timeout_o, 0);
    wait_end(e);
    chk(done_o == 1'b1, "R3 after timeout restart", done_o, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_inv7();
    t_tog6();
    t_sticky_done();
    t_busy_start();
    t_timeout();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule